// File: doc/BRIEF.md
# Two-Dimensional DMA Burst Address Generator

This block turns one rectangular transfer descriptor into an ordered stream of bus burst requests. A descriptor gives a start address, a row length, a row count and a row pitch (stride). The row length and row count are both encoded as the count minus one. The block walks `ylen+1` rows of `xlen+1` bytes each. Each row begins exactly one stride after the start of the row before it, so a gap between rows is skipped rather than transferred.

Each row is cut into bursts of whole data-bus beats. A burst is at most `MAX_BEATS` beats long and never crosses a `PAGE_BYTES` address boundary. The block issues the requests one at a time over a valid/ready request port. One cycle after the final request is taken, a single-cycle done pulse reports the total byte count. A descriptor whose fields break the alignment or pitch rules is refused: it raises a one-cycle error pulse and issues nothing.

Top module: `rowstride_dma_agen`

## Requirements
- R1: After reset `desc_ready` is 1 and `burst_valid`, `done` and `err` are 0.
- R2: A descriptor is taken on a clock edge where `desc_valid` and `desc_ready` are both 1. `desc_ready` is 0 from the cycle after a good descriptor is taken until the cycle in which `done` is high, and it is 1 in that cycle.
- R3: Row r (r = 0..ylen) starts at `desc_addr + r*desc_stride`. Its bursts cover `xlen+1` bytes contiguously and in increasing address order, and rows are issued in increasing r. With `ylen` = 0 the stride is not used and one linear block of `xlen+1` bytes is issued.
- R4: Each beat carries `BUS_BYTES` bytes (default 8). `burst_beats` holds the plain beat count, from 1 to `MAX_BEATS` (default 16). It equals the smallest of three values: the beats left in the row, `MAX_BEATS`, and the beats left before the next `PAGE_BYTES` (4096) boundary.
- R5: No burst crosses a 4096-byte boundary. That is, `burst_addr mod 4096 + burst_beats*8 <= 4096`.
- R6: While `burst_valid` is 1 and `burst_ready` is 0, `burst_addr` and `burst_beats` hold their values in the next cycle.
- R7: `done` is 1 for exactly one cycle, the cycle after the last burst of a descriptor is taken. In that cycle `done_bytes` equals `(xlen+1)*(ylen+1)`.
- R8: A descriptor is refused in any of these cases: `desc_addr` is not a multiple of 8; `xlen+1` is not a multiple of 8; or `ylen` is nonzero and the stride is either not a multiple of 8 or greater than `MAX_STRIDE` (65536). A refused descriptor gives `err` = 1 in the cycle after it is taken, and never gives a burst or a `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block is idle and takes a descriptor |
| desc_addr | input | ADDR_W | Start address of row 0 |
| desc_xlen | input | X_W | Row length in bytes, minus one |
| desc_ylen | input | Y_W | Row count, minus one |
| desc_stride | input | S_W | Distance in bytes between row starts |
| burst_valid | output | 1 | Burst request present |
| burst_ready | input | 1 | Downstream takes the request |
| burst_addr | output | ADDR_W | Burst start address |
| burst_beats | output | BEAT_W | Beats in this burst, 1..MAX_BEATS |
| done | output | 1 | One-cycle pulse after the last burst is taken |
| done_bytes | output | BYTES_W | Total bytes of the finished descriptor |
| err | output | 1 | One-cycle pulse for a refused descriptor |

## Verification
The bench aims at rows that start just below a 4 KB boundary. A generator that ignored the boundary would issue one long burst across it, and one that mis-sized the page remainder would send a wrong first or last beat count. It covers strides with a gap and the largest legal stride. A walker that chained rows contiguously, or that added the stride to the current address instead of the row start, would put later rows at wrong addresses. It also sends misaligned address, length and stride fields, plus a misaligned stride with a single row. A faulty check would then either leak bursts, or refuse a descriptor whose stride is never used. Random back-pressure exercises request hold, and the done pulse is checked for its cycle, its width and its byte count.

// File: rtl/rowstride_dma_pkg.sv
package rowstride_dma_pkg;
  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/rowstride_desc_check.sv
module rowstride_desc_check #(
  parameter int BUS_LOG2   = 3,
  parameter int S_W        = 17,
  parameter int MAX_STRIDE = 65536
) (
  input  logic [BUS_LOG2-1:0] addr_lo,
  input  logic [BUS_LOG2-1:0] xlen_lo,
  input  logic                multi_row,
  input  logic [S_W-1:0]      stride,
  output logic                bad
);
  localparam logic [S_W:0] STRIDE_LIM = (S_W+1)'(MAX_STRIDE);

  logic addr_bad, len_bad, stride_bad;

  always_comb begin
    addr_bad   = |addr_lo;
    // xlen+1 is a multiple of the bus width when the low bits of xlen are all ones
    len_bad    = ~&xlen_lo;
    stride_bad = multi_row &&
                 ((|stride[BUS_LOG2-1:0]) || ({1'b0, stride} > STRIDE_LIM));
    bad        = addr_bad | len_bad | stride_bad;
  end
endmodule

// File: rtl/rowstride_burst_size.sv
module rowstride_burst_size #(
  parameter int BUS_LOG2   = 3,
  parameter int PAGE_LOG2  = 12,
  parameter int RB_W       = 14,
  parameter int MAX_BEATS  = 16,
  parameter int BEAT_W     = 5
) (
  input  logic [PAGE_LOG2-BUS_LOG2-1:0] page_beat_off,
  input  logic [RB_W-1:0]               rem_beats,
  output logic [BEAT_W-1:0]             beats
);
  localparam int P_W = PAGE_LOG2 - BUS_LOG2 + 1;
  localparam int CW0 = (RB_W > P_W) ? RB_W : P_W;
  localparam int CW  = (CW0 > BEAT_W) ? CW0 : BEAT_W;
  localparam logic [P_W-1:0] PAGE_BEATS = P_W'(1 << (PAGE_LOG2 - BUS_LOG2));

  logic [P_W-1:0] to_page;
  logic [CW-1:0]  rem_c, page_c, cap_c, m1, m2;

  always_comb begin
    to_page = PAGE_BEATS - P_W'(page_beat_off);
    rem_c   = CW'(rem_beats);
    page_c  = CW'(to_page);
    cap_c   = CW'(MAX_BEATS);
    m1      = (rem_c < page_c) ? rem_c : page_c;
    m2      = (m1 < cap_c) ? m1 : cap_c;
    beats   = BEAT_W'(m2);
  end
endmodule

// File: rtl/rowstride_walker.sv
module rowstride_walker
  import rowstride_dma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int X_W        = 16,
  parameter int Y_W        = 12,
  parameter int S_W        = 17,
  parameter int BUS_LOG2   = 3,
  parameter int PAGE_LOG2  = 12,
  parameter int RB_W       = 14,
  parameter int MAX_BEATS  = 16,
  parameter int BEAT_W     = 5,
  parameter int BYTES_W    = 30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               desc_valid,
  output logic               desc_ready,
  input  logic [ADDR_W-1:0]  desc_addr,
  input  logic [X_W-1:0]     desc_xlen,
  input  logic [Y_W-1:0]     desc_ylen,
  input  logic [S_W-1:0]     desc_stride,
  input  logic               desc_bad,
  input  logic [BEAT_W-1:0]  beats,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic [RB_W-1:0]    rem_beats,
  output logic               burst_valid,
  input  logic               burst_ready,
  output logic               done,
  output logic [BYTES_W-1:0] done_bytes,
  output logic               err
);
  walk_state_e       st_q, st_d;
  logic [ADDR_W-1:0]  cur_q, cur_d, row_q, row_d;
  logic [RB_W-1:0]    rem_q, rem_d, rowb_q, rowb_d;
  logic [Y_W-1:0]     rows_q, rows_d;
  logic [S_W-1:0]     stride_q, stride_d;
  logic [BYTES_W-1:0] bytes_q, bytes_d;
  logic               done_q, done_d, err_q, err_d;
  logic               accept, take, row_end, ld_en;
  logic [X_W:0]       xp1;
  logic [Y_W:0]       yp1;
  logic [ADDR_W-1:0]  next_row;

  always_comb begin
    accept   = desc_valid && (st_q == WALK_IDLE);
    take     = (st_q == WALK_RUN) && burst_ready;
    row_end  = (RB_W'(beats) == rem_q);
    xp1      = {1'b0, desc_xlen} + 1'b1;
    yp1      = {1'b0, desc_ylen} + 1'b1;
    next_row = row_q + ADDR_W'(stride_q);
    ld_en    = accept || take;
  end

  always_comb begin
    st_d     = st_q;
    cur_d    = cur_q;
    row_d    = row_q;
    rem_d    = rem_q;
    rowb_d   = rowb_q;
    rows_d   = rows_q;
    stride_d = stride_q;
    bytes_d  = bytes_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    if (accept) begin
      if (desc_bad) begin
        err_d = 1'b1;
      end else begin
        st_d     = WALK_RUN;
        cur_d    = desc_addr;
        row_d    = desc_addr;
        rowb_d   = xp1[X_W:BUS_LOG2];
        rem_d    = xp1[X_W:BUS_LOG2];
        rows_d   = desc_ylen;
        stride_d = desc_stride;
        bytes_d  = BYTES_W'(xp1 * yp1);
      end
    end else if (take) begin
      if (row_end) begin
        if (rows_q == '0) begin
          st_d   = WALK_IDLE;
          done_d = 1'b1;
        end else begin
          row_d  = next_row;
          cur_d  = next_row;
          rem_d  = rowb_q;
          rows_d = rows_q - 1'b1;
        end
      end else begin
        cur_d = cur_q + (ADDR_W'(beats) << BUS_LOG2);
        rem_d = rem_q - RB_W'(beats);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= WALK_IDLE;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      cur_q    <= '0;
      row_q    <= '0;
      rem_q    <= '0;
      rowb_q   <= '0;
      rows_q   <= '0;
      stride_q <= '0;
      bytes_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (ld_en) begin
        cur_q    <= cur_d;
        row_q    <= row_d;
        rem_q    <= rem_d;
        rowb_q   <= rowb_d;
        rows_q   <= rows_d;
        stride_q <= stride_d;
        bytes_q  <= bytes_d;
      end
    end
  end

  assign desc_ready  = (st_q == WALK_IDLE);
  assign burst_valid = (st_q == WALK_RUN);
  assign cur_addr    = cur_q;
  assign rem_beats   = rem_q;
  assign done        = done_q;
  assign done_bytes  = bytes_q;
  assign err         = err_q;

  logic [PAGE_LOG2+1:0] end_off;
  always_comb end_off = {2'b00, cur_q[PAGE_LOG2-1:0]} +
                        ((PAGE_LOG2+2)'(beats) << BUS_LOG2);

  // R4
  beats_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> (beats != '0) && (beats <= BEAT_W'(MAX_BEATS)));

  // R5
  page_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> end_off <= (PAGE_LOG2+2)'(1 << PAGE_LOG2));

  // R6
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && !burst_ready) |=> burst_valid && $stable(cur_q) && $stable(beats));

  // R7
  done_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(burst_valid && burst_ready) && !burst_valid && !$past(done_q));

  // R8
  err_no_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !burst_valid && !done_q);

  // R2
  start_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_valid) |-> $past(desc_valid && desc_ready));
endmodule

// File: rtl/rowstride_dma_agen.sv
module rowstride_dma_agen #(
  parameter int ADDR_W     = 32,
  parameter int X_W        = 16,
  parameter int Y_W        = 12,
  parameter int S_W        = 17,
  parameter int BUS_BYTES  = 8,
  parameter int MAX_BEATS  = 16,
  parameter int PAGE_BYTES = 4096,
  parameter int MAX_STRIDE = 65536,
  localparam int BEAT_W    = $clog2(MAX_BEATS) + 1,
  localparam int BYTES_W   = X_W + Y_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               desc_valid,
  output logic               desc_ready,
  input  logic [ADDR_W-1:0]  desc_addr,
  input  logic [X_W-1:0]     desc_xlen,
  input  logic [Y_W-1:0]     desc_ylen,
  input  logic [S_W-1:0]     desc_stride,
  output logic               burst_valid,
  input  logic               burst_ready,
  output logic [ADDR_W-1:0]  burst_addr,
  output logic [BEAT_W-1:0]  burst_beats,
  output logic               done,
  output logic [BYTES_W-1:0] done_bytes,
  output logic               err
);
  localparam int BUS_LOG2  = $clog2(BUS_BYTES);
  localparam int PAGE_LOG2 = $clog2(PAGE_BYTES);
  localparam int RB_W      = X_W + 1 - BUS_LOG2;

  logic              bad;
  logic [BEAT_W-1:0] beats;
  logic [ADDR_W-1:0] cur_addr;
  logic [RB_W-1:0]   rem_beats;

  rowstride_desc_check #(
    .BUS_LOG2(BUS_LOG2), .S_W(S_W), .MAX_STRIDE(MAX_STRIDE)
  ) u_check (
    .addr_lo   (desc_addr[BUS_LOG2-1:0]),
    .xlen_lo   (desc_xlen[BUS_LOG2-1:0]),
    .multi_row (desc_ylen != '0),
    .stride    (desc_stride),
    .bad       (bad)
  );

  rowstride_burst_size #(
    .BUS_LOG2(BUS_LOG2), .PAGE_LOG2(PAGE_LOG2), .RB_W(RB_W),
    .MAX_BEATS(MAX_BEATS), .BEAT_W(BEAT_W)
  ) u_size (
    .page_beat_off (cur_addr[PAGE_LOG2-1:BUS_LOG2]),
    .rem_beats     (rem_beats),
    .beats         (beats)
  );

  rowstride_walker #(
    .ADDR_W(ADDR_W), .X_W(X_W), .Y_W(Y_W), .S_W(S_W), .BUS_LOG2(BUS_LOG2),
    .PAGE_LOG2(PAGE_LOG2), .RB_W(RB_W), .MAX_BEATS(MAX_BEATS),
    .BEAT_W(BEAT_W), .BYTES_W(BYTES_W)
  ) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .desc_valid  (desc_valid),
    .desc_ready  (desc_ready),
    .desc_addr   (desc_addr),
    .desc_xlen   (desc_xlen),
    .desc_ylen   (desc_ylen),
    .desc_stride (desc_stride),
    .desc_bad    (bad),
    .beats       (beats),
    .cur_addr    (cur_addr),
    .rem_beats   (rem_beats),
    .burst_valid (burst_valid),
    .burst_ready (burst_ready),
    .done        (done),
    .done_bytes  (done_bytes),
    .err         (err)
  );

  assign burst_addr  = cur_addr;
  assign burst_beats = beats;
endmodule

// File: tb/rowstride_dma_agen_bench.sv
module rowstride_dma_agen_bench;
  localparam int ADDR_W = 32, X_W = 16, Y_W = 12, S_W = 17;
  localparam int BEAT_W = 5, BYTES_W = X_W + Y_W + 2;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               desc_valid, desc_ready;
  logic [ADDR_W-1:0]  desc_addr;
  logic [X_W-1:0]     desc_xlen;
  logic [Y_W-1:0]     desc_ylen;
  logic [S_W-1:0]     desc_stride;
  logic               burst_valid, burst_ready;
  logic [ADDR_W-1:0]  burst_addr;
  logic [BEAT_W-1:0]  burst_beats;
  logic               done, err;
  logic [BYTES_W-1:0] done_bytes;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rowstride_dma_agen u_rowstride_dma_agen (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_addr(desc_addr), .desc_xlen(desc_xlen), .desc_ylen(desc_ylen),
    .desc_stride(desc_stride), .burst_valid(burst_valid), .burst_ready(burst_ready),
    .burst_addr(burst_addr), .burst_beats(burst_beats), .done(done),
    .done_bytes(done_bytes), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int exp_beats(input longint addr, input int rem);
    int to_page;
    int b;
    to_page = int'((4096 - (addr % 4096)) / 8);
    b = rem;
    if (to_page < b) b = to_page;
    if (16 < b) b = 16;
    return b;
  endfunction

  task automatic run_desc(input longint a, input int x, input int y, input int s,
                          input bit bad, input int rdy_pct);
    longint row, cur;
    int rem, rows, eb, guard;
    bit fin, rd;
    @(negedge clk);
    chk(desc_ready == 1'b1, "R2", "ready before offer", desc_ready, 1);
    desc_valid  = 1'b1;
    desc_addr   = ADDR_W'(a);
    desc_xlen   = X_W'(x);
    desc_ylen   = Y_W'(y);
    desc_stride = S_W'(s);
    burst_ready = 1'b0;
    @(negedge clk);
    desc_valid = 1'b0;
    if (bad) begin
      chk(err == 1'b1, "R8", "err pulse", err, 1);
      chk(burst_valid == 1'b0, "R8", "no burst on refuse", burst_valid, 0);
      @(negedge clk);
      chk(err == 1'b0, "R8", "err one cycle", err, 0);
      chk(burst_valid == 1'b0 && done == 1'b0, "R8", "no burst/done later",
          {burst_valid, done}, 0);
      return;
    end
    chk(err == 1'b0, "R8", "no err on good desc", err, 0);
    chk(desc_ready == 1'b0, "R2", "ready low while busy", desc_ready, 0);
    row = a; cur = a; rem = (x + 1) / 8; rows = y; fin = 0; guard = 0;
    while (!fin) begin
      guard++;
      if (guard > 20000) begin
        chk(0, "R3", "request stream hung", guard, 0);
        return;
      end
      eb = exp_beats(cur, rem);
      chk(burst_valid == 1'b1, "R3", "burst valid", burst_valid, 1);
      chk(burst_addr == ADDR_W'(cur), "R3", "burst addr", burst_addr, cur);
      chk(int'(burst_beats) == eb, "R4", "burst beats", burst_beats, eb);
      chk((longint'(burst_addr) % 4096) + longint'(burst_beats) * 8 <= 4096, "R5",
          "page end offset", (longint'(burst_addr) % 4096) + longint'(burst_beats) * 8, 4096);
      chk(done == 1'b0, "R7", "no done mid transfer", done, 0);
      rd = (($urandom % 100) < rdy_pct);
      burst_ready = rd;
      @(negedge clk);
      if (rd) begin
        if (eb == rem) begin
          if (rows == 0) fin = 1;
          else begin
            row = row + s; cur = row; rem = (x + 1) / 8; rows--;
          end
        end else begin
          cur = cur + eb * 8; rem = rem - eb;
        end
      end else begin
        // R6: held request is rechecked against the unchanged model next pass
        chk(burst_addr == ADDR_W'(cur), "R6", "addr held on stall", burst_addr, cur);
      end
    end
    burst_ready = 1'b0;
    chk(done == 1'b1, "R7", "done after last take", done, 1);
    chk(done_bytes == BYTES_W'(longint'(x + 1) * longint'(y + 1)), "R7", "done bytes",
        done_bytes, longint'(x + 1) * longint'(y + 1));
    chk(burst_valid == 1'b0, "R7", "no burst with done", burst_valid, 0);
    chk(desc_ready == 1'b1, "R2", "ready in done cycle", desc_ready, 1);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done one cycle", done, 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; desc_valid = 1'b0; burst_ready = 1'b0;
    desc_addr = '0; desc_xlen = '0; desc_ylen = '0; desc_stride = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(desc_ready == 1'b1, "R1", "reset ready", desc_ready, 1);
    chk(burst_valid == 1'b0, "R1", "reset burst_valid", burst_valid, 0);
    chk(done == 1'b0 && err == 1'b0, "R1", "reset done/err", {done, err}, 0);

    run_desc(64'h1000, 63, 0, 0, 0, 100);       // R3 linear block
    run_desc(64'h0FC0, 255, 0, 0, 0, 100);      // R5 8,16,8 around page
    run_desc(64'h2000, 7, 3, 24, 0, 60);        // R3 gap rows, one beat each
    run_desc(64'h0F80, 127, 2, 200, 0, 50);     // R5 2D across page
    run_desc(64'h3000, 15, 0, 3, 0, 100);       // R8 stride unused when one row
    run_desc(64'h5000, 7, 1, 65536, 0, 100);    // R8 largest legal stride
    run_desc(64'h8008, 4095, 1, 4096, 0, 70);   // R4 long rows
    run_desc(64'h1004, 63, 0, 0, 1, 100);       // R8 misaligned address
    run_desc(64'h1000, 10, 0, 0, 1, 100);       // R8 misaligned length
    run_desc(64'h1000, 63, 1, 68, 1, 100);      // R8 misaligned stride
    run_desc(64'h1000, 63, 1, 70000, 1, 100);   // R8 stride over limit

    for (int i = 0; i < 40; i++) begin
      int x, y, s;
      longint a;
      bit bad;
      a = longint'($urandom % 32'h40000) & ~64'h7;
      x = ((($urandom % 64) + 1) * 8) - 1;
      y = $urandom % 4;
      s = x + 1 + (($urandom % 8) * 8);
      bad = 0;
      if (($urandom % 8) == 0) begin a = a + 4; bad = 1; end
      run_desc(a, x, y, s, bad, 30 + ($urandom % 71));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule